// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a target (slave) on a two-wire I2C bus. It sees the raw SCL and SDA lines and pulls each line low through an open-drain enable. It answers to one fixed 7-bit address. When a master writes, each received byte goes to local logic over a valid/ready byte port. When a master reads, each byte to send is taken from local logic over a second valid/ready byte port.

Whenever the local side cannot yet accept or supply a byte, the target holds SCL low. The master then waits until the byte moves. Start and stop conditions are recognised in every state. A repeated start therefore restarts address reception at once, even in the middle of a byte. This is what makes the combined write-then-read transfer work.

Top module: `i2c_target_stretch`

## Requirements
- R1: After a synchronous active-low reset, `scl_oe`, `sda_oe`, `rx_valid` and `tx_ready` are all 0.
- R2: SDA falling while SCL is high is a start condition in any state, including mid-byte. The next 8 SCL rising edges are then taken as a fresh address byte; no stop is needed in between.
- R3: SDA rising while SCL is high is a stop condition in any state. The target returns to idle, releases both lines and drops any partial byte, which never appears on `rx_valid`.
- R4: The first byte after a start holds the address in its upper 7 bits, most significant bit first, and the direction in its last bit (1 = read). The target pulls SDA low through the ninth clock only when the address equals `TARGET_ADDR`.
- R5: On an address mismatch the target leaves SDA and SCL undriven and makes no `rx_valid` or `tx_ready` handshake until the next start.
- R6: In a write, each group of 8 bits, sampled on SCL rising edges with the most significant bit first, is shown on `rx_data` with `rx_valid` held steady until `rx_ready`. The target acknowledges the byte only after that handshake.
- R7: In a write, SCL is held low from the falling edge after the eighth data bit until the `rx_valid`/`rx_ready` handshake.
- R8: In a read, a byte is taken when `tx_valid` and `tx_ready` are both high. It is sent most significant bit first, and the target changes its SDA drive only while SCL is low.
- R9: In a read, SCL is held low before each byte from the falling edge that ends the acknowledge slot until `tx_valid` is high.
- R10: After a read byte, SDA low in the ninth clock (master ACK) makes the target fetch the next byte. SDA high (NACK) makes it release SDA and raise no further `tx_ready` until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level (asynchronous) |
| sda_i | input | 1 | Sensed SDA line level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | DATA_W | Byte received from the master |
| rx_valid | output | 1 | `rx_data` holds a complete byte |
| rx_ready | input | 1 | Local logic accepts `rx_data` |
| tx_data | input | DATA_W | Byte to send to the master |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Target is waiting for the next read byte |

## Verification
The bench sweeps all 128 addresses and all 256 write byte values. A wrong address compare would acknowledge a neighbouring address, and a misordered shift would corrupt some data value.

It issues a repeated start three data bits into a byte. A design that kept its bit count would misalign the new address and stay silent. It also stops a write mid-byte; a design that did not flush would hand a partial byte to local logic.

Local latency is set to 60 cycles on both ports. A target that released SCL early would lose or repeat bytes, and the total stretch time is measured. A read ending in NACK checks that SDA is freed for the stop. A monitor flags any change of the target's SDA drive while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C target: the byte-engine state encoding.
package i2c_tgt_pkg;

    // Byte-engine states; one state per bus phase the target can be in.
    typedef enum logic [3:0] {
        ST_IDLE,      // not addressed, watching for a start
        ST_ADDR,      // shifting in address and direction
        ST_ADDR_ACK,  // driving ACK for the address byte
        ST_WR_BITS,   // shifting in a written byte
        ST_WR_HOLD,   // byte complete, stretching until local accept
        ST_WR_ACK,    // driving ACK for a written byte
        ST_RD_LOAD,   // stretching until local byte available
        ST_RD_BITS,   // shifting out a read byte
        ST_RD_ACK     // master's ACK/NACK slot
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Multi-line input synchroniser with one extra history stage.
// Assumes: inputs are asynchronous levels; idle level of every line is 1,
// so all stages reset to 1 and no edge is seen out of reset.
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] now_o,
    output logic [LINES-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] pipe;

        // Shift the raw level through the synchroniser and history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[DEPTH-2:0], raw_i[g]};
        end

        assign now_o[g]  = pipe[STAGES-1];
        assign prev_o[g] = pipe[STAGES];
    end
endmodule

// File: rtl/i2c_tgt_cond.sv
// Bus-event decoder: SCL edges plus start and stop conditions.
// Assumes: inputs are the synchronised current and previous line levels.
// A start or stop needs SCL high in both samples, so an SDA change that
// lands together with an SCL edge is never taken as a condition.
module i2c_tgt_cond (
    input  logic scl_now,
    input  logic scl_prev,
    input  logic sda_now,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_steady_hi;

    // Decode edges and conditions from two successive samples.
    always_comb begin
        scl_steady_hi = scl_now & scl_prev;
        scl_rise      = scl_now & ~scl_prev;
        scl_fall      = ~scl_now & scl_prev;
        start_c       = scl_steady_hi & sda_prev & ~sda_now;
        stop_c        = scl_steady_hi & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte engine of the I2C target: address match, write and read bytes,
// acknowledge slots and clock stretching.
// Assumes: DATA_W = address width + 1. Events come from i2c_tgt_cond.
// Stop has priority over start, and both over any bit activity.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-2:0] TARGET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_bit,
    input  logic              start_c,
    input  logic              stop_c,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              scl_hold,
    output logic              sda_hold
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    tgt_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              is_read;
    logic              m_ack;

    // Advance the bus phase, shift bits and capture direction and ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            is_read <= 1'b0;
            m_ack   <= 1'b0;
        end else if (stop_c) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (start_c) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BITS: begin
                    if (scl_rise && cnt != FULL) begin
                        shreg <= {shreg[DATA_W-2:0], sda_bit};
                        cnt   <= cnt + 1'b1;
                    end
                    if (scl_fall && cnt == FULL) begin
                        if (state == ST_WR_BITS) begin
                            state <= ST_WR_HOLD;
                        end else if (shreg[DATA_W-1:1] == TARGET_ADDR) begin
                            state   <= ST_ADDR_ACK;
                            is_read <= shreg[0];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt   <= '0;
                        state <= is_read ? ST_RD_LOAD : ST_WR_BITS;
                    end
                end
                ST_WR_HOLD: begin
                    if (rx_ready) state <= ST_WR_ACK;
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        cnt   <= '0;
                        state <= ST_WR_BITS;
                    end
                end
                ST_RD_LOAD: begin
                    if (tx_valid) begin
                        shreg <= tx_data;
                        cnt   <= '0;
                        state <= ST_RD_BITS;
                    end
                end
                ST_RD_BITS: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            state <= ST_RD_ACK;
                        end else begin
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) m_ack <= ~sda_bit;
                    if (scl_fall) state <= m_ack ? ST_RD_LOAD : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode line drives and local handshakes from the current phase.
    always_comb begin
        rx_data  = shreg;
        rx_valid = (state == ST_WR_HOLD);
        tx_ready = (state == ST_RD_LOAD);
        scl_hold = (state == ST_WR_HOLD) || (state == ST_RD_LOAD);
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_hold = 1'b1;
            ST_RD_BITS:             sda_hold = ~shreg[DATA_W-1];
            default:                sda_hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_target_stretch.sv
// Top of the I2C target: synchroniser, bus-event decoder and byte engine.
// Assumes: clk runs many times faster than SCL, so every bus phase spans
// several clocks. The pads use open drain: a 1 on an *_oe pulls the line low.
module i2c_target_stretch #(
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-2:0] TARGET_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_now, line_prev;
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_c, stop_c;

    i2c_tgt_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .now_o  (line_now),
        .prev_o (line_prev)
    );

    assign scl_s = line_now[0];
    assign sda_s = line_now[1];
    assign scl_p = line_prev[0];
    assign sda_p = line_prev[1];

    i2c_tgt_cond u_cond (
        .scl_now  (scl_s),
        .scl_prev (scl_p),
        .sda_now  (sda_s),
        .sda_prev (sda_p),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2c_tgt_engine #(.DATA_W(DATA_W), .TARGET_ADDR(TARGET_ADDR)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_bit  (sda_s),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .scl_hold (scl_oe),
        .sda_hold (sda_oe)
    );
endmodule

// File: rtl/i2c_target_stretch_chk.sv
// Protocol checker for i2c_target_stretch, attached by bind below.
// Assumes: scl_sync is the synchronised SCL level inside the top.
module i2c_target_stretch_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              scl_sync
);
    // R1: the first cycle out of reset has every drive and handshake idle.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!scl_oe && !sda_oe && !rx_valid && !tx_ready));

    // R6: an offered byte stays offered and unchanged until accepted.
    a_r6_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R7 and R9: the stretch persists until a local handshake completes.
    a_r7_stretch_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !(rx_valid && rx_ready) && !(tx_valid && tx_ready)) |=> scl_oe);

    // R8: the target starts pulling SDA only while SCL is seen low.
    a_r8_sda_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_sync);

    // R10: receiving and fetching are never both pending.
    a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_ready));
endmodule

bind i2c_target_stretch i2c_target_stretch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .scl_sync (scl_s)
);

// File: tb/sim_i2c_target_stretch.sv
`timescale 1ns/1ps
module sim_i2c_target_stretch;
    localparam int HALF = 8;
    localparam logic [6:0] TADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe;
    logic [7:0] rx_data, tx_data;
    logic rx_valid, rx_ready, tx_valid, tx_ready;

    int n_cmp = 0, n_bad = 0;
    int rx_cnt, tx_cnt, rx_wait, tx_wait;
    int rx_delay = 0, tx_delay = 0;
    int stretch_cyc = 0, sda_viol = 0, sda_oe_cyc = 0;
    logic [7:0] rx_log [0:511];
    bit finished = 1'b0;
    logic scl_q = 1'b1, oe_q = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_target_stretch #(.DATA_W(8), .SYNC_STAGES(2), .TARGET_ADDR(TADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    // Local receive side: accept after rx_delay cycles and log the byte.
    always @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0; rx_cnt <= 0; rx_wait <= 0;
        end else if (rx_valid && rx_ready) begin
            rx_log[rx_cnt % 512] <= rx_data;
            rx_cnt   <= rx_cnt + 1;
            rx_ready <= 1'b0;
            rx_wait  <= 0;
        end else if (rx_valid) begin
            if (rx_wait >= rx_delay) rx_ready <= 1'b1;
            else rx_wait <= rx_wait + 1;
        end
    end

    // Local transmit side: offer pattern byte tx_cnt after tx_delay cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0; tx_cnt <= 0; tx_wait <= 0; tx_data <= 8'h00;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0; tx_cnt <= tx_cnt + 1; tx_wait <= 0;
        end else if (tx_ready && !tx_valid) begin
            if (tx_wait >= tx_delay) begin
                tx_valid <= 1'b1; tx_data <= pat(tx_cnt);
            end else tx_wait <= tx_wait + 1;
        end
    end

    // Line monitors: stretch time, SDA drive time, SDA changes during SCL high.
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_oe) stretch_cyc++;
            if (sda_oe) sda_oe_cyc++;
            if (scl_line && scl_q && (sda_oe != oe_q)) sda_viol++;
        end
        scl_q = scl_line;
        oe_q  = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HALF);
        scl_up();     wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HALF);
        scl_up();     wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wt(HALF);
        scl_up();  wt(HALF);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(HALF);
        scl_up(); wt(HALF / 2);
        b = sda_line; wt(HALF / 2);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(mack);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int base, tbase, st0;

        wt(5);
        // R1: reset state at the ports.
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(!rx_valid && !tx_ready, "R1 handshakes idle", {rx_valid, tx_ready}, 0);
        rst_n = 1'b1; wt(5);

        // R4/R5: sweep all addresses; only TADDR acknowledges.
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({7'(a), 1'b0}, ack);
            chk(ack == (a != int'(TADDR)), "R4 address ack", ack, (a != int'(TADDR)));
            bus_stop();
        end
        chk(rx_cnt == 0, "R5 no bytes from sweep", rx_cnt, 0);

        // R6: write every byte value in one transfer.
        base = rx_cnt;
        bus_start();
        put_byte({TADDR, 1'b0}, ack);
        chk(ack == 1'b0, "R4 write address ack", ack, 0);
        for (int k = 0; k < 256; k++) begin
            put_byte(8'(k), ack);
            chk(ack == 1'b0, "R6 data ack", ack, 0);
        end
        bus_stop(); wt(4);
        chk(rx_cnt == base + 256, "R6 byte count", rx_cnt - base, 256);
        for (int k = 0; k < 256; k++)
            chk(rx_log[(base + k) % 512] == 8'(k), "R6 byte value", rx_log[(base + k) % 512], k);

        // R5: wrong address, then write and read attempts are ignored.
        base = rx_cnt; tbase = tx_cnt; st0 = sda_oe_cyc;
        bus_start();
        put_byte({TADDR ^ 7'h01, 1'b0}, ack);
        chk(ack == 1'b1, "R5 mismatch nack", ack, 1);
        put_byte(8'h00, ack);
        put_byte(8'h5A, ack);
        chk(ack == 1'b1, "R5 data unacked", ack, 1);
        bus_start();
        put_byte({TADDR ^ 7'h40, 1'b1}, ack);
        get_byte(v, 1'b1);
        chk(v == 8'hFF, "R5 read bus undriven", v, 8'hFF);
        bus_stop(); wt(4);
        chk(rx_cnt == base, "R5 no rx handshake", rx_cnt - base, 0);
        chk(tx_cnt == tbase, "R5 no tx handshake", tx_cnt - tbase, 0);
        chk(sda_oe_cyc == st0, "R5 SDA never driven", sda_oe_cyc - st0, 0);

        // R8/R10: read four bytes, NACK the last.
        tbase = tx_cnt;
        bus_start();
        put_byte({TADDR, 1'b1}, ack);
        chk(ack == 1'b0, "R4 read address ack", ack, 0);
        for (int k = 0; k < 4; k++) begin
            get_byte(v, (k == 3));
            chk(v == pat(tbase + k), "R8 read byte", v, pat(tbase + k));
        end
        wt(6);
        chk(!sda_oe && !tx_ready, "R10 released after nack", {sda_oe, tx_ready}, 0);
        chk(tx_cnt == tbase + 4, "R10 fetch count", tx_cnt - tbase, 4);
        bus_stop(); wt(4);

        // R7: write with slow local acceptance.
        rx_delay = 60; base = rx_cnt; stretch_cyc = 0;
        bus_start();
        put_byte({TADDR, 1'b0}, ack);
        for (int k = 0; k < 3; k++) put_byte(8'hC0 + 8'(k), ack);
        bus_stop(); wt(4);
        chk(stretch_cyc >= 180, "R7 write stretch", stretch_cyc, 180);
        chk(rx_cnt == base + 3, "R7 count under stretch", rx_cnt - base, 3);
        for (int k = 0; k < 3; k++)
            chk(rx_log[(base + k) % 512] == 8'hC0 + 8'(k), "R7 byte under stretch",
                rx_log[(base + k) % 512], 8'hC0 + k);
        rx_delay = 0;

        // R9: read with slow local supply.
        tx_delay = 60; tbase = tx_cnt; stretch_cyc = 0;
        bus_start();
        put_byte({TADDR, 1'b1}, ack);
        for (int k = 0; k < 2; k++) begin
            get_byte(v, (k == 1));
            chk(v == pat(tbase + k), "R9 byte under stretch", v, pat(tbase + k));
        end
        bus_stop(); wt(4);
        chk(stretch_cyc >= 120, "R9 read stretch", stretch_cyc, 120);
        tx_delay = 0;

        // R2: combined write then repeated start and read.
        base = rx_cnt; tbase = tx_cnt;
        bus_start();
        put_byte({TADDR, 1'b0}, ack);
        put_byte(8'h3C, ack);
        bus_start();
        put_byte({TADDR, 1'b1}, ack);
        chk(ack == 1'b0, "R2 repeated start ack", ack, 0);
        get_byte(v, 1'b0);
        chk(v == pat(tbase), "R2 combined read 0", v, pat(tbase));
        get_byte(v, 1'b1);
        chk(v == pat(tbase + 1), "R2 combined read 1", v, pat(tbase + 1));
        bus_stop(); wt(4);
        chk(rx_cnt == base + 1 && rx_log[base % 512] == 8'h3C, "R2 combined write",
            rx_log[base % 512], 8'h3C);

        // R2: repeated start three bits into a byte resynchronises.
        base = rx_cnt;
        bus_start();
        put_byte({TADDR, 1'b0}, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte({TADDR, 1'b0}, ack);
        chk(ack == 1'b0, "R2 mid-byte restart ack", ack, 0);
        put_byte(8'hA5, ack);
        bus_stop(); wt(4);
        chk(rx_cnt == base + 1, "R2 no partial byte", rx_cnt - base, 1);
        chk(rx_log[base % 512] == 8'hA5, "R2 byte after restart", rx_log[base % 512], 8'hA5);

        // R3: stop four bits into a byte drops the partial byte.
        base = rx_cnt;
        bus_start();
        put_byte({TADDR, 1'b0}, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop(); wt(6);
        chk(rx_cnt == base && !rx_valid, "R3 partial byte dropped", rx_cnt - base, 0);
        chk(!sda_oe && !scl_oe, "R3 lines released", {sda_oe, scl_oe}, 0);

        // R8: target never changed its SDA drive while SCL was high.
        chk(sda_viol == 0, "R8 SDA change on SCL low only", sda_viol, 0);

        finish_run();
    end
endmodule